// File: doc/BRIEF.md
# CSR Access Legality and Read-Modify-Write Unit

This unit sits between the decode stage of a RISC-V core and the storage of its control and status registers. For each access it receives four things: the 12-bit register address, the current privilege level, the kind of operation and the operand. It also receives some machine context: a debugger-access flag, whether the supervisor extension is implemented, the floating-point state field, and the two counter-enable words. From these inputs it decides in the same cycle whether the access is allowed.

When the access is allowed, the unit returns the register's present value, which is supplied by the storage as `old_value`. It also computes the value to commit and raises a write strobe only when some bit is actually targeted. A successful write to a floating-point control register also asks the status storage to mark the floating-point state dirty.

When the access is not allowed, the unit raises `illegal`. In that same cycle the strobe stays low and the read data is forced to zero.

The storage behind each register, and any side effect of an individual register, live outside this unit. The unit is parameterized on the data width, which is 32 or 64 bits.

Top module: `csr_access_unit`

## Requirements
- R1: An access fails when `cur_priv` (user=0, supervisor=1, machine=3) is numerically below address bits [9:8].
- R2: An address whose bits [11:10] are both 1 is read-only; any access to it whose effective mask is nonzero fails, and one with a zero mask is legal.
- R3: `op_sel` 0 reads (mask zero); 1 writes (mask all ones, new value = operand); 2 sets (mask = operand, new value all ones); 3 clears (mask = operand, new value zero).
- R4: For a legal access `rdata` equals `old_value` and `wdata` is (old AND NOT mask) OR (new AND mask); `wr_en` rises only when the mask is nonzero; an illegal access returns zero on `rdata`.
- R5: Addresses 0x001 to 0x003 (floating-point flags, rounding mode, combined) fail while `fs_state` is 0, unless `dbg_access` is 1.
- R6: `fs_make_dirty` is 1 exactly when `wr_en` is 1 for an address from 0x001 to 0x003.
- R7: For the user counters at 0xC00 to 0xC1F, the access is gated by an enable mask that starts as all ones. Below machine level the mask is ANDed with `mcounten`, and at user level it is also ANDed with `scounten`. The access fails unless the mask bit indexed by address bits [4:0] is 1.
- R8: Supervisor registers (0x100, 0x104 to 0x106, 0x140 to 0x144, 0x180) fail when `has_smode` is 0.
- R9: Addresses with no implemented register fail. This includes 0xC01 and any address outside the decoded set.
- R10: `illegal` is combinational and forces `wr_en` low in the same cycle; with `acc_valid` low, `illegal`, `wr_en` and `fs_make_dirty` are all 0.
- R11: The high-half counters (0xC80 to 0xC9F, 0xB80 to 0xB9F) exist only when XLEN is 32; at XLEN 64 they fail as undefined.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_valid | input | 1 | An access is presented this cycle |
| csr_addr | input | 12 | Register address |
| cur_priv | input | 2 | Current privilege level |
| op_sel | input | 2 | Operation kind: read, write, set, clear |
| operand | input | XLEN | Source operand |
| dbg_access | input | 1 | Access comes from the debugger |
| has_smode | input | 1 | Supervisor extension implemented |
| fs_state | input | 2 | Floating-point state field of the status register |
| mcounten | input | 32 | Machine-level counter enables |
| scounten | input | 32 | Supervisor-level counter enables |
| old_value | input | XLEN | Present value read from storage |
| illegal | output | 1 | Access refused |
| rdata | output | XLEN | Value returned to the destination register |
| wdata | output | XLEN | Merged value to commit |
| wr_en | output | 1 | Commit strobe |
| fs_make_dirty | output | 1 | Request to set the floating-point state to dirty |

## Verification
A fault verdict and a write request can arrive in the same cycle. This happens when a mask-bearing operation targets a read-only, under-privileged, gated or undefined address. The bench provokes this collision with full writes to a read-only identifier and to a disabled counter. It also uses a write to a floating-point register while its state is off. For each case it requires `illegal` high, `wr_en` and `fs_make_dirty` low, and `rdata` zero. As a contrast, a clear with a zero operand to the same read-only address must pass without a strobe.

// File: rtl/csr_acc_pkg.sv
// Shared types and constants for the CSR access unit.
// Assumes the privilege encoding user=0, supervisor=1, machine=3.
package csr_acc_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        GRP_NONE  = 3'd0,
        GRP_FP    = 3'd1,
        GRP_UCNT  = 3'd2,
        GRP_SUPER = 3'd3,
        GRP_MACH  = 3'd4
    } csr_group_e;

    // Upper seven address bits that select a 32-entry counter bank.
    localparam logic [6:0] BANK_UCNT_LO = 7'h60;  // 0xC00..0xC1F
    localparam logic [6:0] BANK_UCNT_HI = 7'h64;  // 0xC80..0xC9F
    localparam logic [6:0] BANK_MCNT_LO = 7'h58;  // 0xB00..0xB1F
    localparam logic [6:0] BANK_MCNT_HI = 7'h5C;  // 0xB80..0xB9F
    localparam logic [6:0] BANK_MEVENT  = 7'h19;  // 0x320..0x33F

    // Counter slot 1 (real-time) has no implemented register here.
    localparam logic [4:0] SLOT_TIME  = 5'd1;
    // Event selectors start at slot 3.
    localparam logic [4:0] SLOT_EVT_FIRST = 5'd3;

endpackage

// File: rtl/csr_addr_decode.sv
// Classifies a CSR address into its gating group and yields the counter
// slot index. Assumes XLEN is 32 or 64; the upper-half counter banks
// exist only for XLEN 32 and are chosen by a generate branch.
module csr_addr_decode
    import csr_acc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [11:0] addr,
    output csr_group_e  group,
    output logic [4:0]  slot
);

    localparam bit HAS_HIGH_HALF = (XLEN == 32);

    logic [6:0] bank;
    logic       slot_is_time;
    logic       hi_ucnt;
    logic       hi_mcnt;
    logic       is_fp;
    logic       is_sup;
    logic       is_mach_fixed;
    logic       is_mach_cnt;
    logic       is_mevent;

    assign bank         = addr[11:5];
    assign slot         = addr[4:0];
    assign slot_is_time = (addr[4:0] == SLOT_TIME);

    // Upper-half counter banks only when the word is 32 bits wide.
    generate
        if (HAS_HIGH_HALF) begin : g_high_half
            assign hi_ucnt = (bank == BANK_UCNT_HI) && !slot_is_time;
            assign hi_mcnt = (bank == BANK_MCNT_HI) && !slot_is_time;
        end else begin : g_no_high_half
            assign hi_ucnt = 1'b0;
            assign hi_mcnt = 1'b0;
        end
    endgenerate

    // Match the fixed-address register sets of each group.
    always_comb begin
        is_fp  = (addr == 12'h001) || (addr == 12'h002) || (addr == 12'h003);
        is_sup = (addr == 12'h100) ||
                 (addr >= 12'h104 && addr <= 12'h106) ||
                 (addr >= 12'h140 && addr <= 12'h144) ||
                 (addr == 12'h180);
        is_mach_fixed = (addr >= 12'h300 && addr <= 12'h306) ||
                        (addr >= 12'h340 && addr <= 12'h344) ||
                        (addr >= 12'hF11 && addr <= 12'hF14);
        is_mach_cnt = ((bank == BANK_MCNT_LO) && !slot_is_time) || hi_mcnt;
        is_mevent   = (bank == BANK_MEVENT) && (addr[4:0] >= SLOT_EVT_FIRST);
    end

    // Pick one group; unmatched addresses are undefined.
    always_comb begin
        group = GRP_NONE;
        if (is_fp) begin
            group = GRP_FP;
        end else if (((bank == BANK_UCNT_LO) && !slot_is_time) || hi_ucnt) begin
            group = GRP_UCNT;
        end else if (is_sup) begin
            group = GRP_SUPER;
        end else if (is_mach_fixed || is_mach_cnt || is_mevent) begin
            group = GRP_MACH;
        end
    end

endmodule

// File: rtl/csr_access_gate.sv
// Decides whether an access is refused. Combines the privilege floor and
// read-only marker carried in the address with the group predicates:
// floating-point state gate (debugger bypass), two-level counter enables,
// and supervisor-extension presence. Purely combinational.
module csr_access_gate
    import csr_acc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [3:0]       addr_top,   // address bits [11:8]
    input  csr_group_e       group,
    input  logic [$clog2(CNT_W)-1:0] slot,
    input  priv_e            priv_lvl,
    input  logic             mask_nz,
    input  logic             dbg_access,
    input  logic             has_smode,
    input  logic [1:0]       fs_state,
    input  logic [CNT_W-1:0] mcounten,
    input  logic [CNT_W-1:0] scounten,
    output logic             fail
);

    logic             priv_fail;
    logic             ro_fail;
    logic             pred_fail;
    logic [CNT_W-1:0] cnt_mask;

    // Privilege floor from bits [9:8]; read-only marker from bits [11:10].
    always_comb begin
        priv_fail = (priv_lvl < priv_e'(addr_top[1:0]));
        ro_fail   = (addr_top[3:2] == 2'b11) && mask_nz;
    end

    // Build the counter enable mask level by level.
    always_comb begin
        cnt_mask = '1;
        if (priv_lvl < PRIV_MACH) begin
            cnt_mask = cnt_mask & mcounten;
        end
        if (priv_lvl < PRIV_SUPER) begin
            cnt_mask = cnt_mask & scounten;
        end
    end

    // Group predicate.
    always_comb begin
        unique case (group)
            GRP_FP:    pred_fail = (fs_state == 2'b00) && !dbg_access;
            GRP_UCNT:  pred_fail = !cnt_mask[slot];
            GRP_SUPER: pred_fail = !has_smode;
            GRP_MACH:  pred_fail = 1'b0;
            default:   pred_fail = 1'b1;
        endcase
    end

    // Combine every reason into one verdict.
    assign fail = priv_fail || ro_fail || pred_fail;

endmodule

// File: rtl/csr_rmw_merge.sv
// Turns the operation kind and operand into a bit mask and a new value,
// then merges them with the present register value. Assumes a read
// carries a zero mask so that it never produces a commit.
module csr_rmw_merge
    import csr_acc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  csr_op_e           op,
    input  logic [XLEN-1:0]   operand,
    input  logic [XLEN-1:0]   old_value,
    output logic [XLEN-1:0]   merged,
    output logic              mask_nz
);

    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] newv;

    // Expand the operation into mask and value.
    always_comb begin
        unique case (op)
            OP_READ:  begin mask = '0;      newv = '0;      end
            OP_WRITE: begin mask = '1;      newv = operand; end
            OP_SET:   begin mask = operand; newv = '1;      end
            default:  begin mask = operand; newv = '0;      end
        endcase
    end

    // Bitwise merge and mask occupancy.
    always_comb begin
        merged  = (old_value & ~mask) | (newv & mask);
        mask_nz = |mask;
    end

endmodule

// File: rtl/csr_access_unit.sv
// Top of the CSR access path: decode, legality gate and read-modify-write
// merge. All outputs are combinational in the inputs; the refusal verdict
// blocks the commit strobe in the same cycle. Assumes XLEN is 32 or 64.
module csr_access_unit
    import csr_acc_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int CNT_W = 32
) (
    input  logic             acc_valid,
    input  logic [11:0]      csr_addr,
    input  logic [1:0]       cur_priv,
    input  logic [1:0]       op_sel,
    input  logic [XLEN-1:0]  operand,
    input  logic             dbg_access,
    input  logic             has_smode,
    input  logic [1:0]       fs_state,
    input  logic [CNT_W-1:0] mcounten,
    input  logic [CNT_W-1:0] scounten,
    input  logic [XLEN-1:0]  old_value,
    output logic             illegal,
    output logic [XLEN-1:0]  rdata,
    output logic [XLEN-1:0]  wdata,
    output logic             wr_en,
    output logic             fs_make_dirty
);

    localparam int SLOT_W = $clog2(CNT_W);

    csr_group_e      group;
    logic [4:0]      slot_raw;
    logic            mask_nz;
    logic            fail;
    logic            granted;
    logic [XLEN-1:0] merged;

    csr_addr_decode #(.XLEN(XLEN)) u_decode (
        .addr  (csr_addr),
        .group (group),
        .slot  (slot_raw)
    );

    csr_rmw_merge #(.XLEN(XLEN)) u_merge (
        .op        (csr_op_e'(op_sel)),
        .operand   (operand),
        .old_value (old_value),
        .merged    (merged),
        .mask_nz   (mask_nz)
    );

    csr_access_gate #(.CNT_W(CNT_W)) u_gate (
        .addr_top   (csr_addr[11:8]),
        .group      (group),
        .slot       (slot_raw[SLOT_W-1:0]),
        .priv_lvl   (priv_e'(cur_priv)),
        .mask_nz    (mask_nz),
        .dbg_access (dbg_access),
        .has_smode  (has_smode),
        .fs_state   (fs_state),
        .mcounten   (mcounten),
        .scounten   (scounten),
        .fail       (fail)
    );

    // Qualify the verdict with the access strobe and drive the outputs.
    always_comb begin
        granted       = acc_valid && !fail;
        illegal       = acc_valid && fail;
        rdata         = granted ? old_value : '0;
        wdata         = merged;
        wr_en         = granted && mask_nz;
        fs_make_dirty = granted && mask_nz && (group == GRP_FP);
    end

endmodule

// File: rtl/csr_access_checker.sv
// Assertion checker for csr_access_unit, attached by bind. Checks
// relations among ports that separate pieces of logic drive.
module csr_access_checker
    import csr_acc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            acc_valid,
    input logic [11:0]     csr_addr,
    input logic [1:0]      cur_priv,
    input logic [1:0]      op_sel,
    input logic [XLEN-1:0] operand,
    input logic            dbg_access,
    input logic [1:0]      fs_state,
    input logic            illegal,
    input logic [XLEN-1:0] wdata,
    input logic            wr_en,
    input logic            fs_make_dirty
);

    logic fp_addr;
    assign fp_addr = (csr_addr >= 12'h001) && (csr_addr <= 12'h003);

    // Immediate checks over the settled combinational outputs.
    always_comb begin
        if (!acc_valid) begin
            p_idle_quiet_r10: assert (!illegal && !wr_en && !fs_make_dirty)
                else $error("idle cycle produced activity");
        end
        p_fault_blocks_strobe_r10: assert (!(illegal && wr_en))
            else $error("strobe raised with refusal");
        if (acc_valid && !illegal) begin
            p_priv_floor_r1: assert (cur_priv >= csr_addr[9:8])
                else $error("granted below privilege floor");
        end
        if (wr_en) begin
            p_ro_unwritten_r2: assert (csr_addr[11:10] != 2'b11)
                else $error("commit to read-only address");
        end
        if (op_sel == OP_READ) begin
            p_read_no_commit_r3: assert (!wr_en)
                else $error("plain read committed");
        end
        if (wr_en && op_sel == OP_WRITE) begin
            p_write_copies_operand_r3: assert (wdata == operand)
                else $error("full write value differs from operand");
        end
        if (acc_valid && !illegal && fp_addr && !dbg_access) begin
            p_fp_gate_r5: assert (fs_state != 2'b00)
                else $error("fp access granted with state off");
        end
        if (fs_make_dirty) begin
            p_dirty_needs_commit_r6: assert (wr_en && fp_addr)
                else $error("dirty request without fp commit");
        end
    end

endmodule

bind csr_access_unit csr_access_checker #(.XLEN(XLEN)) u_chk (
    .acc_valid     (acc_valid),
    .csr_addr      (csr_addr),
    .cur_priv      (cur_priv),
    .op_sel        (op_sel),
    .operand       (operand),
    .dbg_access    (dbg_access),
    .fs_state      (fs_state),
    .illegal       (illegal),
    .wdata         (wdata),
    .wr_en         (wr_en),
    .fs_make_dirty (fs_make_dirty)
);

// File: tb/tb_csr_access_unit.sv
`timescale 1ns/1ps
module tb_csr_access_unit;

    localparam int XLEN = 64;
    localparam logic [63:0] OLDV = 64'h1234_5678_9ABC_DEF0;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    typedef struct packed {
        logic [11:0] addr;
        logic [1:0]  priv;
        logic [1:0]  op;
        logic [63:0] opd;
        logic        dbg;
        logic        hs;
        logic [1:0]  fs;
        logic [31:0] mc;
        logic [31:0] sc;
        logic        ex_ill;
        logic        ex_we;
        logic [63:0] ex_wd;
        logic        ex_dirty;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    // op: 0 read, 1 write, 2 set, 3 clear; priv: 0 U, 1 S, 3 M
    localparam vec_t VECS [NV] = '{
        '{12'h340, 2'd3, 2'd0, 64'h0, 1'b0, 1'b1, 2'd1, ONES, ONES, 1'b0, 1'b0, 64'h0, 1'b0, 4'd4},                 // R4 plain read
        '{12'h340, 2'd3, 2'd1, 64'hA5A5_A5A5_5A5A_5A5A, 1'b0, 1'b1, 2'd1, ONES, ONES, 1'b0, 1'b1, 64'hA5A5_A5A5_5A5A_5A5A, 1'b0, 4'd3}, // R3 write
        '{12'h340, 2'd3, 2'd2, 64'h0F, 1'b0, 1'b1, 2'd1, ONES, ONES, 1'b0, 1'b1, 64'h1234_5678_9ABC_DEFF, 1'b0, 4'd3}, // R3 set
        '{12'h340, 2'd3, 2'd3, 64'hF0, 1'b0, 1'b1, 2'd1, ONES, ONES, 1'b0, 1'b1, 64'h1234_5678_9ABC_DE00, 1'b0, 4'd3}, // R3 clear
        '{12'h340, 2'd3, 2'd2, 64'h0, 1'b0, 1'b1, 2'd1, ONES, ONES, 1'b0, 1'b0, 64'h0, 1'b0, 4'd4},                 // R4 zero mask
        '{12'h340, 2'd1, 2'd0, 64'h0, 1'b0, 1'b1, 2'd1, ONES, ONES, 1'b1, 1'b0, 64'h0, 1'b0, 4'd1},                 // R1 S on M reg
        '{12'h105, 2'd1, 2'd1, 64'h8000_0100, 1'b0, 1'b1, 2'd1, ONES, ONES, 1'b0, 1'b1, 64'h8000_0100, 1'b0, 4'd1}, // R1 S on S reg
        '{12'h105, 2'd0, 2'd0, 64'h0, 1'b0, 1'b1, 2'd1, ONES, ONES, 1'b1, 1'b0, 64'h0, 1'b0, 4'd1},                 // R1 U on S reg
        '{12'hF14, 2'd3, 2'd0, 64'h0, 1'b0, 1'b1, 2'd1, ONES, ONES, 1'b0, 1'b0, 64'h0, 1'b0, 4'd2},                 // R2 read ro
        '{12'hF14, 2'd3, 2'd1, 64'h5, 1'b0, 1'b1, 2'd1, ONES, ONES, 1'b1, 1'b0, 64'h0, 1'b0, 4'd2},                 // R2 write ro
        '{12'hF14, 2'd3, 2'd3, 64'h0, 1'b0, 1'b1, 2'd1, ONES, ONES, 1'b0, 1'b0, 64'h0, 1'b0, 4'd2},                 // R2 clear zero
        '{12'h001, 2'd0, 2'd0, 64'h0, 1'b0, 1'b1, 2'd0, ONES, ONES, 1'b1, 1'b0, 64'h0, 1'b0, 4'd5},                 // R5 fs off
        '{12'h001, 2'd0, 2'd0, 64'h0, 1'b1, 1'b1, 2'd0, ONES, ONES, 1'b0, 1'b0, 64'h0, 1'b0, 4'd5},                 // R5 debugger
        '{12'h003, 2'd0, 2'd1, 64'hE5, 1'b0, 1'b1, 2'd1, ONES, ONES, 1'b0, 1'b1, 64'hE5, 1'b1, 4'd6},               // R6 dirty
        '{12'h002, 2'd0, 2'd0, 64'h0, 1'b0, 1'b1, 2'd3, ONES, ONES, 1'b0, 1'b0, 64'h0, 1'b0, 4'd6},                 // R6 read no dirty
        '{12'hC00, 2'd0, 2'd0, 64'h0, 1'b0, 1'b1, 2'd1, 32'h1, 32'h0, 1'b1, 1'b0, 64'h0, 1'b0, 4'd7},               // R7 U blocked by s
        '{12'hC00, 2'd1, 2'd0, 64'h0, 1'b0, 1'b1, 2'd1, 32'h1, 32'h0, 1'b0, 1'b0, 64'h0, 1'b0, 4'd7},               // R7 S ignores s
        '{12'hC02, 2'd1, 2'd0, 64'h0, 1'b0, 1'b1, 2'd1, 32'hFFFF_FFFB, ONES, 1'b1, 1'b0, 64'h0, 1'b0, 4'd7},        // R7 S blocked by m
        '{12'hC02, 2'd3, 2'd0, 64'h0, 1'b0, 1'b1, 2'd1, 32'h0, 32'h0, 1'b0, 1'b0, 64'h0, 1'b0, 4'd7},               // R7 M ungated
        '{12'hC1F, 2'd0, 2'd0, 64'h0, 1'b0, 1'b1, 2'd1, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 64'h0, 1'b0, 4'd7}, // R7 top slot
        '{12'h140, 2'd3, 2'd0, 64'h0, 1'b0, 1'b0, 2'd1, ONES, ONES, 1'b1, 1'b0, 64'h0, 1'b0, 4'd8},                 // R8 no S ext
        '{12'h140, 2'd3, 2'd0, 64'h0, 1'b0, 1'b1, 2'd1, ONES, ONES, 1'b0, 1'b0, 64'h0, 1'b0, 4'd8},                 // R8 S ext
        '{12'h7C0, 2'd3, 2'd0, 64'h0, 1'b0, 1'b1, 2'd1, ONES, ONES, 1'b1, 1'b0, 64'h0, 1'b0, 4'd9},                 // R9 undefined
        '{12'hC01, 2'd3, 2'd0, 64'h0, 1'b0, 1'b1, 2'd1, ONES, ONES, 1'b1, 1'b0, 64'h0, 1'b0, 4'd9},                 // R9 time slot
        '{12'hC80, 2'd3, 2'd0, 64'h0, 1'b0, 1'b1, 2'd1, ONES, ONES, 1'b1, 1'b0, 64'h0, 1'b0, 4'd11},                // R11 high half
        '{12'h302, 2'd3, 2'd1, 64'hB109, 1'b0, 1'b1, 2'd1, ONES, ONES, 1'b0, 1'b1, 64'hB109, 1'b0, 4'd3}            // R3 write M reg
    };

    logic            clk = 1'b0;
    logic            acc_valid;
    logic [11:0]     csr_addr;
    logic [1:0]      cur_priv;
    logic [1:0]      op_sel;
    logic [XLEN-1:0] operand;
    logic            dbg_access;
    logic            has_smode;
    logic [1:0]      fs_state;
    logic [31:0]     mcounten;
    logic [31:0]     scounten;
    logic [XLEN-1:0] old_value;
    logic            illegal;
    logic [XLEN-1:0] rdata;
    logic [XLEN-1:0] wdata;
    logic            wr_en;
    logic            fs_make_dirty;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    csr_access_unit #(.XLEN(XLEN)) dut (
        .acc_valid     (acc_valid),
        .csr_addr      (csr_addr),
        .cur_priv      (cur_priv),
        .op_sel        (op_sel),
        .operand       (operand),
        .dbg_access    (dbg_access),
        .has_smode     (has_smode),
        .fs_state      (fs_state),
        .mcounten      (mcounten),
        .scounten      (scounten),
        .old_value     (old_value),
        .illegal       (illegal),
        .rdata         (rdata),
        .wdata         (wdata),
        .wr_en         (wr_en),
        .fs_make_dirty (fs_make_dirty)
    );

    task automatic check(input string what, input int req,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        acc_valid  = 1'b1;
        csr_addr   = v.addr;
        cur_priv   = v.priv;
        op_sel     = v.op;
        operand    = v.opd;
        dbg_access = v.dbg;
        has_smode  = v.hs;
        fs_state   = v.fs;
        mcounten   = v.mc;
        scounten   = v.sc;
        old_value  = OLDV;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        acc_valid = 1'b0; csr_addr = 12'h0; cur_priv = 2'd3; op_sel = 2'd0;
        operand = '0; dbg_access = 1'b0; has_smode = 1'b1; fs_state = 2'd1;
        mcounten = ONES; scounten = ONES; old_value = OLDV;

        // R10 quiet state before any access
        @(negedge clk);
        check("idle illegal", 10, {63'd0, illegal}, 64'd0);
        check("idle wr_en", 10, {63'd0, wr_en}, 64'd0);
        check("idle rdata", 4, rdata, 64'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(posedge clk); #1;
            apply(VECS[i]);
            @(negedge clk);
            check($sformatf("v%0d illegal", i), int'(VECS[i].req), {63'd0, illegal}, {63'd0, VECS[i].ex_ill});
            check($sformatf("v%0d wr_en", i), int'(VECS[i].req), {63'd0, wr_en}, {63'd0, VECS[i].ex_we});
            check($sformatf("v%0d dirty", i), int'(VECS[i].req), {63'd0, fs_make_dirty}, {63'd0, VECS[i].ex_dirty});
            check($sformatf("v%0d rdata", i), int'(VECS[i].req), rdata, VECS[i].ex_ill ? 64'd0 : OLDV);
            if (VECS[i].ex_we)
                check($sformatf("v%0d wdata", i), int'(VECS[i].req), wdata, VECS[i].ex_wd);
        end

        // R10: refused fp write with state off: no strobe, no dirty
        @(posedge clk); #1;
        acc_valid = 1'b1; csr_addr = 12'h003; cur_priv = 2'd3; op_sel = 2'd1;
        operand = 64'h7; fs_state = 2'd0; dbg_access = 1'b0;
        @(negedge clk);
        check("fp write fs off illegal", 10, {63'd0, illegal}, 64'd1);
        check("fp write fs off wr_en", 10, {63'd0, wr_en}, 64'd0);
        check("fp write fs off dirty", 6, {63'd0, fs_make_dirty}, 64'd0);

        // R10: same refused inputs with no access presented
        @(posedge clk); #1;
        acc_valid = 1'b0; csr_addr = 12'hF14; op_sel = 2'd1;
        @(negedge clk);
        check("invalid illegal", 10, {63'd0, illegal}, 64'd0);
        check("invalid wr_en", 10, {63'd0, wr_en}, 64'd0);

        // R7 with R10: full write to a disabled counter
        @(posedge clk); #1;
        acc_valid = 1'b1; csr_addr = 12'hC03; cur_priv = 2'd0; op_sel = 2'd1;
        fs_state = 2'd1; mcounten = ONES; scounten = 32'hFFFF_FFF7;
        @(negedge clk);
        check("gated counter illegal", 7, {63'd0, illegal}, 64'd1);
        check("gated counter wr_en", 10, {63'd0, wr_en}, 64'd0);

        // R3: set with all ones reaches all ones; clear all reaches zero
        @(posedge clk); #1;
        csr_addr = 12'h341; cur_priv = 2'd3; op_sel = 2'd2; operand = '1;
        @(negedge clk);
        check("set all", 3, wdata, '1);
        @(posedge clk); #1;
        op_sel = 2'd3;
        @(negedge clk);
        check("clear all", 3, wdata, 64'd0);

        @(posedge clk); #1;
        acc_valid = 1'b0;
        finish_run();
    end

endmodule